// File: doc/BRIEF.md
# Hashed Page Table Group Search

This block looks up a translation in a small on-chip hashed page table. The caller supplies a virtual page number, a page-size shift, a segment-size flag, a 64-bit target first doubleword and a group mask. The block hashes the page number and derives a primary group and a secondary group from that hash. It then walks the eight entries of each group, one entry per clock. It stops at the first entry that satisfies the match rule. It reports whether an entry matched, in which group and slot it sits, and the entry's second doubleword.

The table holds 2^GIDX_W groups of eight entries. Each entry is a pair of 64-bit doublewords. A host write port loads entries one row at a time. Row addresses are `{group, slot}`.

The control is a five-state machine:
- S_IDLE: waits for `start`.
- S_HASH: registers both group indices.
- S_PRIMARY: scans the primary group.
- S_SECONDARY: scans the secondary group.
- S_DONE: presents `done` for one cycle.

The transitions are:
- T_ACCEPT (S_IDLE to S_HASH on start).
- T_HASHED (S_HASH to S_PRIMARY).
- T_PRI_HIT (S_PRIMARY to S_DONE).
- T_PRI_EXHAUST (S_PRIMARY to S_SECONDARY after slot 7).
- T_SEC_HIT (S_SECONDARY to S_DONE).
- T_SEC_MISS (S_SECONDARY to S_DONE after slot 7).
- T_RETIRE (S_DONE to S_IDLE).

Top module: `hpt_group_search`

## Requirements
- R1: After reset, `busy`, `done`, `hit` and `secondary` are 0, `slot` is 0 and `match_r` is 0. Every table row is cleared, so a search started before any write misses.
- R2: When `seg_1t`=0, the hash is computed as follows, keeping bits 38:0:
  - Shift the VPN right by 16.
  - Take VPN bits 15:0 and shift them right by (`page_shift`-12).
  - XOR the two results.
- R3: When `seg_1t`=1, let s = VPN >> 28. The hash is computed as follows, keeping bits 38:0:
  - Take s.
  - Take s shifted left by 25.
  - Take VPN bits 27:0 shifted right by (`page_shift`-12).
  - XOR all three.
- R4: The primary group is hash[GIDX_W-1:0] AND `hash_mask`. The secondary group is the bitwise complement of hash[GIDX_W-1:0] AND `hash_mask`. The entry in slot k of group g lives at row g*8+k.
- R5: An entry matches only if bit 0 of its first doubleword (valid) is 1. The entry's first doubleword must also equal `target_v` in bits 63:7, which include the segment-size field in bits 63:62. Bits 6:0 are ignored for equality; this covers the large-page flag (bit 2) and the bolted flag (bit 4).
- R6: During the primary scan an entry is accepted only when its bit 1 (secondary flag) is 0. During the secondary scan an entry is accepted only when bit 1 is 1.
- R7: Entries are examined in this order: primary slots 0..7, then secondary slots 0..7. The first accepted entry ends the search. A hit reports `hit`=1, `secondary` = the group it was found in, `slot` = k, and `match_r` = that entry's second doubleword.
- R8: Let edge 0 be the clock edge that accepts `start`. The `done` output rises after:
  - edge 2+k for a primary hit in slot k;
  - edge 10+k for a secondary hit in slot k;
  - edge 17 for a miss.

  `done` lasts exactly one cycle. `busy` is 1 from edge 0 up to and including the `done` cycle.
- R9: A miss reports `hit`=0, `secondary`=0, `slot`=0 and `match_r`=0.
- R10: The result outputs change only on the edge that raises `done`. They are held through the following idle time and through the next search until that search completes.
- R11: `start` is ignored while `busy` is 1. The search in progress and its result are unaffected.
- R12: A host write takes effect at the clock edge where `wr_en` is sampled. A compare of the same row in the cycle that ends at that edge sees the row's previous contents. Later searches see the new contents.
- R13: `page_shift` must be at least 12 whenever a search is accepted. A value of exactly 12 uses every in-segment VPN bit unshifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a search (accepted only when idle) |
| vpn | input | 64 | Virtual page number to look up |
| page_shift | input | 6 | Base page size as a log2 byte count, 12 or more |
| seg_1t | input | 1 | 1 selects the 1 TB segment hash, 0 the 256 MB hash |
| target_v | input | 64 | First-doubleword value to match (bits 6:0 ignored) |
| hash_mask | input | GIDX_W | Mask applied to the hash to form group indices |
| wr_en | input | 1 | Host table write strobe |
| wr_row | input | GIDX_W+3 | Host write row, {group, slot} |
| wr_v | input | 64 | First doubleword to write |
| wr_r | input | 64 | Second doubleword to write |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| hit | output | 1 | A matching entry was found |
| secondary | output | 1 | Match was in the secondary group |
| slot | output | 3 | Slot of the matching entry |
| match_r | output | 64 | Second doubleword of the matching entry |

## Verification
Two functions of the block can fall in the same cycle: a host write and the sequential compare. The bench preloads a matching entry in primary slot 0. It starts a search and drives a write to that same row during the exact cycle in which slot 0 is compared. The write replaces the row with an invalid entry carrying a different second doubleword. The search must still report the old second doubleword at the slot-0 latency, and a repeat search afterwards must reflect the new contents. A second overlap, a fresh `start` pulse arriving mid-scan, is judged by the search's result being unchanged.

// File: rtl/hpt_pkg.sv
`timescale 1ns/1ps
package hpt_pkg;

    localparam int DW     = 64;
    localparam int SLOTS  = 8;
    localparam int SLOT_W = $clog2(SLOTS);

    // First-doubleword field positions used by the matcher
    localparam int V_VALID_BIT  = 0;
    localparam int V_SECOND_BIT = 1;
    localparam int V_IGNORE_W   = 7;

    typedef enum logic [2:0] {
        S_IDLE,
        S_HASH,
        S_PRIMARY,
        S_SECONDARY,
        S_DONE
    } srch_state_e;

    typedef struct packed {
        logic [DW-1:0] v;
        logic [DW-1:0] r;
    } pte_t;

    typedef struct packed {
        logic              hit;
        logic              sec;
        logic [SLOT_W-1:0] slot;
        logic [DW-1:0]     r;
    } result_t;

endpackage

// File: rtl/hpt_hash.sv
`timescale 1ns/1ps
module hpt_hash #(
    parameter int HASH_W     = 39,
    parameter int SHORT_SEG  = 28,
    parameter int LONG_SEG   = 40,
    parameter int PAGE_BASE  = 12,
    parameter int FOLD_SHIFT = 25
) (
    input  logic [63:0]       vpn,
    input  logic [5:0]        page_shift,
    input  logic              seg_1t,
    output logic [HASH_W-1:0] hash
);
    localparam int SHORT_LOW = SHORT_SEG - PAGE_BASE;
    localparam int LONG_LOW  = LONG_SEG - PAGE_BASE;
    localparam logic [63:0] SHORT_KEEP = (64'd1 << SHORT_LOW) - 64'd1;
    localparam logic [63:0] LONG_KEEP  = (64'd1 << LONG_LOW) - 64'd1;

    logic [5:0]  in_page_off;
    logic [63:0] seg_id;
    logic [63:0] wide;
    logic        unused_wide_hi;

    assign in_page_off = page_shift - 6'(PAGE_BASE);

    always_comb begin
        seg_id = vpn >> LONG_LOW;
        if (seg_1t) begin
            wide = seg_id ^ (seg_id << FOLD_SHIFT) ^ ((vpn & LONG_KEEP) >> in_page_off);
        end else begin
            wide = (vpn >> SHORT_LOW) ^ ((vpn & SHORT_KEEP) >> in_page_off);
        end
    end

    assign hash           = wide[HASH_W-1:0];
    assign unused_wide_hi = ^wide[63:HASH_W];

endmodule

// File: rtl/hpt_table.sv
`timescale 1ns/1ps
module hpt_table
    import hpt_pkg::*;
#(
    parameter int GIDX_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [GIDX_W+SLOT_W-1:0] wr_row,
    input  pte_t                     wr_data,
    input  logic [GIDX_W+SLOT_W-1:0] rd_row,
    output pte_t                     rd_data
);
    localparam int ROW_W = GIDX_W + SLOT_W;
    localparam int ROWS  = 1 << ROW_W;

    pte_t rows_q [ROWS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ROWS; i++) begin
                rows_q[i] <= '0;
            end
        end else if (wr_en) begin
            rows_q[wr_row] <= wr_data;
        end
    end

    assign rd_data = rows_q[rd_row];

endmodule

// File: rtl/hpt_entry_match.sv
`timescale 1ns/1ps
module hpt_entry_match
    import hpt_pkg::*;
(
    input  logic [DW-1:0] entry_v,
    input  logic [DW-1:0] target_v,
    input  logic          probe_sec,
    output logic          match
);
    logic [DW-1:0] diff;
    logic          upper_equal;

    assign diff        = entry_v ^ target_v;
    assign upper_equal = (diff[DW-1:V_IGNORE_W] == '0);
    assign match       = entry_v[V_VALID_BIT] && upper_equal
                         && (entry_v[V_SECOND_BIT] == probe_sec);

endmodule

// File: rtl/hpt_group_search.sv
`timescale 1ns/1ps
module hpt_group_search
    import hpt_pkg::*;
#(
    parameter int GIDX_W = 3,
    parameter int HASH_W = 39
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [63:0]              vpn,
    input  logic [5:0]               page_shift,
    input  logic                     seg_1t,
    input  logic [63:0]              target_v,
    input  logic [GIDX_W-1:0]        hash_mask,
    input  logic                     wr_en,
    input  logic [GIDX_W+SLOT_W-1:0] wr_row,
    input  logic [63:0]              wr_v,
    input  logic [63:0]              wr_r,
    output logic                     busy,
    output logic                     done,
    output logic                     hit,
    output logic                     secondary,
    output logic [SLOT_W-1:0]        slot,
    output logic [63:0]              match_r
);
    localparam int ROW_W = GIDX_W + SLOT_W;
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

    srch_state_e state_q, state_d;

    logic [63:0]        vpn_q, tgt_q;
    logic [5:0]         shift_q;
    logic               seg_q;
    logic [GIDX_W-1:0]  mask_q, grp_pri_q, grp_sec_q;
    logic [SLOT_W-1:0]  idx_q;
    result_t            res_q;

    logic [HASH_W-1:0]  hash_w;
    logic               unused_hash_hi;
    logic               probe_sec, scanning, raw_match, entry_hit, last_slot;
    logic [ROW_W-1:0]   rd_row;
    pte_t               rd_entry, wr_entry;

    hpt_hash #(.HASH_W(HASH_W)) u_hash (
        .vpn        (vpn_q),
        .page_shift (shift_q),
        .seg_1t     (seg_q),
        .hash       (hash_w)
    );

    assign unused_hash_hi = ^hash_w[HASH_W-1:GIDX_W];

    assign probe_sec = (state_q == S_SECONDARY);
    assign scanning  = (state_q == S_PRIMARY) || probe_sec;
    assign last_slot = (idx_q == LAST_SLOT);
    assign rd_row    = {probe_sec ? grp_sec_q : grp_pri_q, idx_q};
    assign wr_entry  = {wr_v, wr_r};

    hpt_table #(.GIDX_W(GIDX_W)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_row  (wr_row),
        .wr_data (wr_entry),
        .rd_row  (rd_row),
        .rd_data (rd_entry)
    );

    hpt_entry_match u_match (
        .entry_v   (rd_entry.v),
        .target_v  (tgt_q),
        .probe_sec (probe_sec),
        .match     (raw_match)
    );

    assign entry_hit = scanning && raw_match;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:      if (start) state_d = S_HASH;                       // T_ACCEPT
            S_HASH:      state_d = S_PRIMARY;                               // T_HASHED
            S_PRIMARY: begin
                if (entry_hit)      state_d = S_DONE;                       // T_PRI_HIT
                else if (last_slot) state_d = S_SECONDARY;                  // T_PRI_EXHAUST
            end
            S_SECONDARY: begin
                if (entry_hit || last_slot) state_d = S_DONE;               // T_SEC_HIT / T_SEC_MISS
            end
            S_DONE:      state_d = S_IDLE;                                  // T_RETIRE
            default:     state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Request capture, scan pointer and results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vpn_q     <= '0;
            tgt_q     <= '0;
            shift_q   <= 6'd12;
            seg_q     <= 1'b0;
            mask_q    <= '0;
            grp_pri_q <= '0;
            grp_sec_q <= '0;
            idx_q     <= '0;
            res_q     <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (start) begin
                        vpn_q   <= vpn;
                        tgt_q   <= target_v;
                        shift_q <= page_shift;
                        seg_q   <= seg_1t;
                        mask_q  <= hash_mask;
                    end
                end
                S_HASH: begin
                    grp_pri_q <=  hash_w[GIDX_W-1:0] & mask_q;
                    grp_sec_q <= ~hash_w[GIDX_W-1:0] & mask_q;
                    idx_q     <= '0;
                end
                S_PRIMARY: begin
                    if (entry_hit) begin
                        res_q <= '{hit: 1'b1, sec: 1'b0, slot: idx_q, r: rd_entry.r};
                    end else begin
                        idx_q <= last_slot ? '0 : idx_q + 1'b1;
                    end
                end
                S_SECONDARY: begin
                    if (entry_hit) begin
                        res_q <= '{hit: 1'b1, sec: 1'b1, slot: idx_q, r: rd_entry.r};
                    end else if (last_slot) begin
                        res_q <= '0;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                S_DONE: ;
                default: ;
            endcase
        end
    end

    assign busy      = (state_q != S_IDLE);
    assign done      = (state_q == S_DONE);
    assign hit       = res_q.hit;
    assign secondary = res_q.sec;
    assign slot      = res_q.slot;
    assign match_r   = res_q.r;

    // R8: completion is a single-cycle pulse
    a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: busy only rises on an accepted start
    a_r8_busy_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R10: results move only with done
    a_r10_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable({hit, secondary, slot, match_r}));

    // R11: captured request is frozen while busy
    a_r11_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable({vpn_q, tgt_q, shift_q, seg_q, mask_q}));

    // R9: a miss leaves clean result fields
    a_r9_miss_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !hit) |-> (!secondary && slot == '0 && match_r == '0));

    // R7: primary exhaustion moves on to the secondary group
    a_r7_scan_order: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_PRIMARY && last_slot && !entry_hit) |=> (state_q == S_SECONDARY));

    // R13: page shift floor at acceptance
    a_r13_shift_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |-> (page_shift >= 6'd12));

endmodule

// File: tb/hpt_group_search_test.sv
`timescale 1ns/1ps
module hpt_group_search_test;

    localparam int GW = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] vpn = '0;
    logic [5:0]  page_shift = 6'd12;
    logic        seg_1t = 1'b0;
    logic [63:0] target_v = '0;
    logic [GW-1:0] hash_mask = '0;
    logic        wr_en = 1'b0;
    logic [GW+2:0] wr_row = '0;
    logic [63:0] wr_v = '0;
    logic [63:0] wr_r = '0;
    logic        busy, done, hit, secondary;
    logic [2:0]  slot;
    logic [63:0] match_r;

    int n_checks = 0;
    int n_fail   = 0;

    logic [63:0] m_v [64];
    logic [63:0] m_r [64];

    hpt_group_search #(.GIDX_W(GW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .vpn(vpn), .page_shift(page_shift),
        .seg_1t(seg_1t), .target_v(target_v), .hash_mask(hash_mask),
        .wr_en(wr_en), .wr_row(wr_row), .wr_v(wr_v), .wr_r(wr_r),
        .busy(busy), .done(done), .hit(hit), .secondary(secondary),
        .slot(slot), .match_r(match_r)
    );

    always #2 clk = ~clk;

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R8 watchdog: actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    task automatic check_eq(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [38:0] ref_hash(input logic [63:0] pn, input int ps, input bit t);
        logic [63:0] h, s;
        if (!t) begin
            h = (pn >> 16) ^ ((pn & 64'h0000_0000_0000_FFFF) >> (ps - 12));
        end else begin
            s = pn >> 28;
            h = s ^ (s << 25) ^ ((pn & 64'h0000_0000_0FFF_FFFF) >> (ps - 12));
        end
        return h[38:0];
    endfunction

    function automatic logic [2:0] grp_of(input logic [63:0] pn, input int ps, input bit t,
                                          input logic [2:0] m, input bit sec);
        logic [38:0] h;
        h = ref_hash(pn, ps, t);
        return sec ? (~h[2:0] & m) : (h[2:0] & m);
    endfunction

    task automatic model_search(input logic [63:0] pn, input int ps, input bit t,
                                input logic [63:0] tgt, input logic [2:0] m,
                                output logic eh, output logic es, output logic [2:0] eslot,
                                output logic [63:0] er, output int elat);
        eh = 0; es = 0; eslot = 0; er = 0; elat = 17;
        for (int s = 0; s < 2; s++) begin
            for (int k = 0; k < 8; k++) begin
                logic [5:0]  row;
                logic [63:0] ev;
                row = {grp_of(pn, ps, t, m, s[0]), k[2:0]};
                ev  = m_v[row];
                if (!eh && ev[0] && (ev[1] == s[0]) && (((ev ^ tgt) >> 7) == 64'd0)) begin
                    eh = 1; es = s[0]; eslot = k[2:0]; er = m_r[row]; elat = 2 + 8 * s + k;
                end
            end
        end
    endtask

    task automatic host_write(input logic [5:0] row, input logic [63:0] v, input logic [63:0] r);
        @(negedge clk);
        wr_en = 1'b1; wr_row = row; wr_v = v; wr_r = r;
        @(negedge clk);
        wr_en = 1'b0;
        m_v[row] = v; m_r[row] = r;
    endtask

    task automatic plant(input logic [5:0] row, input logic [63:0] tgt, input bit sec,
                         input bit valid, input logic [63:0] r);
        logic [63:0] v;
        v = {tgt[63:7], 7'($urandom)};
        v[1] = sec;
        v[0] = valid;
        host_write(row, v, r);
    endtask

    task automatic run_search(input string tag, input logic [63:0] pn, input int ps, input bit t,
                              input logic [63:0] tgt, input logic [2:0] m,
                              input int wr_at, input logic [5:0] wrow,
                              input logic [63:0] wv, input logic [63:0] wrr, input bit poke);
        logic eh, es; logic [2:0] eslot; logic [63:0] er; int elat; int n;
        logic h0, s0; logic [2:0] sl0; logic [63:0] r0;
        model_search(pn, ps, t, tgt, m, eh, es, eslot, er, elat);
        @(negedge clk);
        vpn = pn; page_shift = 6'(ps); seg_1t = t; target_v = tgt; hash_mask = m; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        check_eq({tag, " R8 busy after accept"}, 64'(busy), 64'd1);
        n = 0;
        while (n < 40) begin
            @(posedge clk); n++; #1;
            if (wr_at == n) begin
                wr_en = 1'b1; wr_row = wrow; wr_v = wv; wr_r = wrr;
            end else if (wr_at > 0 && n == wr_at + 1) begin
                wr_en = 1'b0; m_v[wrow] = wv; m_r[wrow] = wrr;
            end
            if (poke && n == 3) begin start = 1'b1; vpn = ~pn; target_v = ~tgt; end
            if (poke && n == 4) start = 1'b0;
            if (done) break;
        end
        check_eq({tag, " R8 latency"}, 64'(n), 64'(elat));
        check_eq({tag, " R7 hit"}, 64'(hit), 64'(eh));
        check_eq({tag, " R7 secondary"}, 64'(secondary), 64'(es));
        check_eq({tag, " R7 slot"}, 64'(slot), 64'(eslot));
        check_eq({tag, " R7 match_r"}, match_r, er);
        h0 = hit; s0 = secondary; sl0 = slot; r0 = match_r;
        @(posedge clk); #1;
        check_eq({tag, " R8 done drops"}, 64'(done), 64'd0);
        check_eq({tag, " R8 idle after done"}, 64'(busy), 64'd0);
        check_eq({tag, " R10 result held"}, {r0[59:0], h0, s0, sl0[1:0]} ^ 64'(sl0[2]),
                 {match_r[59:0], hit, secondary, slot[1:0]} ^ 64'(slot[2]));
    endtask

    initial begin
        logic [63:0] pn, tgt;
        logic [2:0]  g, g2;
        void'($urandom(32'd7321));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 64; i++) begin m_v[i] = '0; m_r[i] = '0; end

        // R1 reset state
        check_eq("R1 busy", 64'(busy), 64'd0);
        check_eq("R1 done", 64'(done), 64'd0);
        check_eq("R1 hit", 64'(hit), 64'd0);
        check_eq("R1 slot", 64'(slot), 64'd0);
        check_eq("R1 match_r", match_r, 64'd0);
        // R1 / R9 empty table misses
        run_search("R1 R9 empty", 64'h0123_4567_89AB_CDEF, 12, 1'b0, 64'h0000_0000_0000_0081,
                   3'b111, 0, 6'd0, 64'd0, 64'd0, 1'b0);

        for (int i = 0; i < 64; i++) host_write(6'(i), {$urandom, $urandom}, {$urandom, $urandom});

        // R2 R4 R13: 256 MB hash, page_shift 12, primary slot 0
        pn = {$urandom, $urandom}; tgt = {$urandom, $urandom};
        g = grp_of(pn, 12, 1'b0, 3'b111, 1'b0);
        plant({g, 3'd0}, tgt, 1'b0, 1'b1, 64'hAAAA_0000_0000_0001);
        run_search("R2 R4 R13 prim slot0", pn, 12, 1'b0, tgt, 3'b111, 0, 6'd0, 64'd0, 64'd0, 1'b0);

        // R2: larger page shift, primary slot 7
        pn = {$urandom, $urandom}; tgt = {$urandom, $urandom};
        g = grp_of(pn, 24, 1'b0, 3'b101, 1'b0);
        plant({g, 3'd7}, tgt, 1'b0, 1'b1, 64'hAAAA_0000_0000_0007);
        run_search("R2 prim slot7", pn, 24, 1'b0, tgt, 3'b101, 0, 6'd0, 64'd0, 64'd0, 1'b0);

        // R3: 1 TB hash, secondary slot 3
        pn = {$urandom, $urandom}; tgt = {$urandom, $urandom};
        g = grp_of(pn, 16, 1'b1, 3'b111, 1'b1);
        plant({g, 3'd3}, tgt, 1'b1, 1'b1, 64'hBBBB_0000_0000_0003);
        run_search("R3 R6 sec slot3", pn, 16, 1'b1, tgt, 3'b111, 0, 6'd0, 64'd0, 64'd0, 1'b0);

        // R3: 1 TB hash, page_shift 28, primary slot 4
        pn = {$urandom, $urandom}; tgt = {$urandom, $urandom};
        g = grp_of(pn, 28, 1'b1, 3'b011, 1'b0);
        plant({g, 3'd4}, tgt, 1'b0, 1'b1, 64'hBBBB_0000_0000_0004);
        run_search("R3 prim slot4", pn, 28, 1'b1, tgt, 3'b011, 0, 6'd0, 64'd0, 64'd0, 1'b0);

        // R4: mask zero puts both groups at 0; secondary-flag entry found in second pass
        pn = {$urandom, $urandom}; tgt = {$urandom, $urandom};
        plant(6'd2, tgt, 1'b1, 1'b1, 64'hCCCC_0000_0000_0002);
        run_search("R4 R6 mask0 sec slot2", pn, 20, 1'b0, tgt, 3'b000, 0, 6'd0, 64'd0, 64'd0, 1'b0);

        // R6: wrong secondary flag in each group -> miss
        pn = {$urandom, $urandom}; tgt = {$urandom, $urandom};
        g  = grp_of(pn, 12, 1'b0, 3'b111, 1'b0);
        g2 = grp_of(pn, 12, 1'b0, 3'b111, 1'b1);
        plant({g, 3'd1}, tgt, 1'b1, 1'b1, 64'hDDDD_0000_0000_0001);
        plant({g2, 3'd5}, tgt, 1'b0, 1'b1, 64'hDDDD_0000_0000_0005);
        run_search("R6 R9 flag mismatch", pn, 12, 1'b0, tgt, 3'b111, 0, 6'd0, 64'd0, 64'd0, 1'b0);

        // R5: invalid match skipped, valid one with flag bits in low field taken
        pn = {$urandom, $urandom}; tgt = {$urandom, $urandom};
        g = grp_of(pn, 12, 1'b0, 3'b111, 1'b0);
        plant({g, 3'd0}, tgt, 1'b0, 1'b0, 64'hEEEE_0000_0000_0000);
        host_write({g, 3'd4}, {tgt[63:7], 7'b001_0101}, 64'hEEEE_0000_0000_0004);
        run_search("R5 invalid skipped", pn, 12, 1'b0, tgt, 3'b111, 0, 6'd0, 64'd0, 64'd0, 1'b0);

        // R5: segment-size field differs -> miss
        pn = {$urandom, $urandom}; tgt = {2'b01, 62'($urandom)};
        g = grp_of(pn, 12, 1'b0, 3'b111, 1'b0);
        host_write({g, 3'd2}, {2'b00, tgt[61:7], 7'b000_0001}, 64'hEEEE_0000_0000_0002);
        run_search("R5 B field differs", pn, 12, 1'b0, tgt, 3'b111, 0, 6'd0, 64'd0, 64'd0, 1'b0);

        // R7: first match wins across slots and groups
        pn = {$urandom, $urandom}; tgt = {$urandom, $urandom};
        g  = grp_of(pn, 14, 1'b0, 3'b111, 1'b0);
        g2 = grp_of(pn, 14, 1'b0, 3'b111, 1'b1);
        plant({g, 3'd6}, tgt, 1'b0, 1'b1, 64'hF000_0000_0000_0006);
        plant({g, 3'd2}, tgt, 1'b0, 1'b1, 64'hF000_0000_0000_0002);
        plant({g2, 3'd0}, tgt, 1'b1, 1'b1, 64'hF000_0000_0000_0010);
        run_search("R7 first match", pn, 14, 1'b0, tgt, 3'b111, 0, 6'd0, 64'd0, 64'd0, 1'b0);

        // R12: write to the row being compared in the same cycle
        pn = {$urandom, $urandom}; tgt = {$urandom, $urandom};
        g = grp_of(pn, 12, 1'b0, 3'b111, 1'b0);
        plant({g, 3'd0}, tgt, 1'b0, 1'b1, 64'h1212_0000_0000_000A);
        run_search("R12 same-cycle write", pn, 12, 1'b0, tgt, 3'b111, 1, {g, 3'd0},
                   64'd0, 64'h1212_0000_0000_000B, 1'b0);
        run_search("R12 after write", pn, 12, 1'b0, tgt, 3'b111, 0, 6'd0, 64'd0, 64'd0, 1'b0);

        // R11: start pulse during a search is ignored
        pn = {$urandom, $urandom}; tgt = {$urandom, $urandom};
        run_search("R11 start while busy", pn, 12, 1'b1, tgt, 3'b110, 0, 6'd0, 64'd0, 64'd0, 1'b1);

        // R7: constrained random mix
        for (int i = 0; i < 40; i++) begin
            int ps; bit t; logic [2:0] m; int mode; logic [2:0] k;
            pn = {$urandom, $urandom}; tgt = {$urandom, $urandom};
            t = 1'($urandom); ps = 12 + int'($urandom % 17); m = 3'($urandom);
            mode = int'($urandom % 3); k = 3'($urandom);
            if (mode != 0) begin
                g = grp_of(pn, ps, t, m, mode == 2);
                plant({g, k}, tgt, mode == 2, 1'b1, {$urandom, $urandom});
            end
            run_search("R7 random", pn, ps, t, tgt, m, 0, 6'd0, 64'd0, 64'd0, 1'b0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule